// File: doc/BRIEF.md
# Single-Memory Accumulator Processor

A compact stored-program processor whose instructions and data sit in one memory array, reached through one address bus and one data bus. It loops forever over fetch and execute: it reads the instruction word at the program counter, advances the counter, decodes the word, and then does only the memory traffic that the instruction calls for. That traffic is one operand read for arithmetic and loads, one write for stores, and nothing for jumps and no-ops.

Each 16-bit word carries a 4-bit opcode and a 12-bit operand address. Arithmetic takes the accumulator as its implicit second source and writes the result back to it. A zero flag and a negative flag follow each arithmetic result, and the zero flag steers the conditional jump. The memory is synchronous: the address and write strobe are driven in one cycle, and read data comes back in the next. A halted output and a copy of the accumulator let the surrounding system see progress.

Top module: `acc_cpu`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the block drives address 0 with the write strobe low. The accumulator reads 0 and halted is low. Reset also clears a halted state.
- R2: An instruction word holds its opcode in bits 15:12 and its operand address in bits 11:0. The opcodes are LOAD=1, STORE=2, ADD=3, SUB=4, JMP=5, JZ=6 and HALT=15.
- R3: Every instruction starts with a fetch cycle that puts the program counter on the address bus. The word is captured in the following cycle, and the counter then advances by one (modulo 4096) before execution.
- R4: LOAD, ADD and SUB each drive their operand address with the strobe low in the cycle after decode. In the next cycle they take the returned data into the accumulator: LOAD copies the data.
- R5: ADD produces the accumulator plus the operand, and SUB produces the accumulator minus the operand. Both wrap modulo 2^16.
- R6: STORE makes exactly one memory access: a single write cycle in which the operand address, the strobe high and the accumulator value appear together.
- R7: The zero flag (result equal to 0) and the negative flag (result bit 15) change only on LOAD, ADD and SUB. STORE, JMP, JZ and no-ops leave them as they were.
- R8: JMP always loads the program counter from the operand address. JZ does so only when the zero flag is set; otherwise execution continues with the next word.
- R9: After HALT, the halted output rises and stays high until reset. No later cycle asserts the write strobe, and the accumulator no longer changes.
- R10: Opcodes 0 and 7 to 14 act as no-ops. They make no memory access beyond the fetch, and the program counter advances by one.
- R11: An instruction takes 4 cycles if it reads an operand and 3 cycles otherwise, counted from its fetch cycle to the next fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Shared memory address |
| mem_wdata | output | 16 | Data to write into memory |
| mem_we | output | 1 | Write strobe; low means a read cycle |
| mem_rdata | input | 16 | Read data, valid one cycle after the address |
| halted | output | 1 | High once HALT has executed |
| acc_dbg | output | 16 | Current accumulator value |

## Verification
On every cycle, the embedded assertions check the following: the counter step after each decode, that a halt lasts until reset, that write strobes are never back to back and never occur while halted, that the flags hold across stores and jumps, and that the flags agree with the accumulator after every arithmetic update. Other behaviours show up only in the bench's programs, whose bus trace is compared cycle by cycle with an instruction-level interpreter. Those are the values the accumulator actually takes, wrapping of sums and differences, JZ being taken or skipped, per-instruction cycle counts, no-op opcodes, and a reset that leaves a halted state.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [AW+3:0] mem_wdata,
  output logic          mem_we,
  input  logic [AW+3:0] mem_rdata,
  output logic          halted,
  output logic [AW+3:0] acc_dbg
);
  localparam int DW = AW + 4;
  localparam logic [3:0] OP_LOAD  = 4'h1;
  localparam logic [3:0] OP_STORE = 4'h2;
  localparam logic [3:0] OP_ADD   = 4'h3;
  localparam logic [3:0] OP_SUB   = 4'h4;
  localparam logic [3:0] OP_JMP   = 4'h5;
  localparam logic [3:0] OP_JZ    = 4'h6;
  localparam logic [3:0] OP_HALT  = 4'hF;

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_EXEC, S_READ, S_HALT} st_t;

  st_t           st;
  logic [AW-1:0] pc;
  logic [DW-1:0] ir, acc, res;
  logic          zf, nf;

  wire [3:0]    op  = ir[DW-1:AW];
  wire [AW-1:0] opa = ir[AW-1:0];
  wire          exe = (st == S_EXEC);

  assign mem_addr  = exe ? opa : pc;
  assign mem_we    = exe && (op == OP_STORE);
  assign mem_wdata = acc;
  assign halted    = (st == S_HALT);
  assign acc_dbg   = acc;

  always_comb begin
    case (op)
      OP_ADD:  res = acc + mem_rdata;
      OP_SUB:  res = acc - mem_rdata;
      default: res = mem_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_FETCH;
      pc  <= '0;
      ir  <= '0;
      acc <= '0;
      zf  <= 1'b0;
      nf  <= 1'b0;
    end else begin
      case (st)
        S_FETCH:  st <= S_DECODE;
        S_DECODE: begin
          ir <= mem_rdata;
          pc <= pc + 1'b1;
          st <= S_EXEC;
        end
        S_EXEC: begin
          st <= S_FETCH;
          case (op)
            OP_LOAD, OP_ADD, OP_SUB: st <= S_READ;
            OP_JMP:  pc <= opa;
            OP_JZ:   if (zf) pc <= opa;
            OP_HALT: st <= S_HALT;
            default: ;
          endcase
        end
        S_READ: begin
          acc <= res;
          zf  <= (res == '0);
          nf  <= res[DW-1];
          st  <= S_FETCH;
        end
        default: st <= S_HALT;
      endcase
    end
  end

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_DECODE) |=> (pc == $past(pc) + 1'b1));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_we && $stable(acc_dbg)));

  // R6
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (exe && (op == OP_STORE || op == OP_JMP || op == OP_JZ)) |=> ($stable(zf) && $stable(nf)));

  // R7
  flag_match_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_READ) |=> ((zf == (acc == '0)) && (nf == acc[DW-1])));

  // R4
  acc_only_read_chk: assert property (@(posedge clk) disable iff (rst)
    (st != S_READ) |=> $stable(acc));
endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, acc_dbg;
  logic        mem_we, halted;

  always #2.5 clk = ~clk;

  acc_cpu u_dut (.clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
                 .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted), .acc_dbg(acc_dbg));

  logic [15:0] dmem [0:4095];
  logic [15:0] rmem [0:4095];

  always @(posedge clk) begin
    mem_rdata <= dmem[mem_addr];
    if (mem_we) dmem[mem_addr] = mem_wdata;
  end

  typedef struct {
    bit          ca;
    logic [11:0] a;
    logic        we;
    logic [15:0] wd;
    logic        h;
    logic [15:0] acc;
    string       tag;
  } ent_t;

  ent_t        q[$];
  int          total = 0, bad = 0, cyc = 0;
  bit          done = 0;
  logic [11:0] m_pc;
  logic [15:0] m_acc;
  bit          m_z, m_h;

  task automatic push(bit ca, logic [11:0] a, logic we, logic [15:0] wd, logic h, string tag);
    ent_t e;
    e.ca = ca; e.a = a; e.we = we; e.wd = wd; e.h = h; e.acc = m_acc; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step();
    logic [15:0] w, d;
    logic [3:0]  op;
    logic [11:0] a;
    if (m_h) begin push(0, 0, 0, 0, 1, "R9"); return; end
    push(1, m_pc, 0, 0, 0, "R3 R11");
    w = rmem[m_pc];
    m_pc = m_pc + 12'd1;
    push(0, 0, 0, 0, 0, "R2 R3");
    op = w[15:12]; a = w[11:0];
    case (op)
      4'h1, 4'h3, 4'h4: begin
        push(1, a, 0, 0, 0, "R4");
        push(0, 0, 0, 0, 0, "R4 R11");
        d = rmem[a];
        if (op == 4'h3) m_acc = m_acc + d;
        else if (op == 4'h4) m_acc = m_acc - d;
        else m_acc = d;
        m_z = (m_acc == 16'h0);
      end
      4'h2: begin push(1, a, 1, m_acc, 0, "R6"); rmem[a] = m_acc; end
      4'h5: begin push(0, 0, 0, 0, 0, "R8"); m_pc = a; end
      4'h6: begin push(0, 0, 0, 0, 0, "R7 R8"); if (m_z) m_pc = a; end
      4'hF: begin push(0, 0, 0, 0, 0, "R9"); m_h = 1; end
      default: push(0, 0, 0, 0, 0, "R10");
    endcase
  endtask

  task automatic fail(string tag, string what, logic [31:0] act, logic [31:0] exp);
    bad++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic compare();
    ent_t e;
    bit ok;
    if (q.size() == 0) step();
    e = q.pop_front();
    total++;
    ok = 1;
    if (mem_we !== e.we) begin fail(e.tag, "we", {31'd0, mem_we}, {31'd0, e.we}); ok = 0; end
    if (ok && e.ca && mem_addr !== e.a) begin fail(e.tag, "addr", {20'd0, mem_addr}, {20'd0, e.a}); ok = 0; end
    if (ok && e.we && mem_wdata !== e.wd) begin fail(e.tag, "wdata", {16'd0, mem_wdata}, {16'd0, e.wd}); ok = 0; end
    if (ok && halted !== e.h) begin fail(e.tag, "halted", {31'd0, halted}, {31'd0, e.h}); ok = 0; end
    if (ok && acc_dbg !== e.acc) fail(e.tag, "acc", {16'd0, acc_dbg}, {16'd0, e.acc});
  endtask

  task automatic put(int ad, logic [15:0] v);
    dmem[ad] = v; rmem[ad] = v;
  endtask

  task automatic clear();
    for (int i = 0; i < 4096; i++) begin dmem[i] = 16'h0; rmem[i] = 16'h0; end
  endtask

  task automatic run(int n);
    m_pc = 0; m_acc = 0; m_z = 0; m_h = 0;
    q.delete();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if (mem_we !== 1'b0 || halted !== 1'b0 || acc_dbg !== 16'h0 || mem_addr !== 12'h0)
      fail("R1", "reset state", {mem_we, halted, acc_dbg, 2'b0, mem_addr}, 32'h0);
    rst = 1'b0;
    compare();
    for (int k = 1; k < n; k++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic check_mem(int ad, string tag);
    total++;
    if (dmem[ad] !== rmem[ad]) fail(tag, "memory", {16'd0, dmem[ad]}, {16'd0, rmem[ad]});
  endtask

  initial begin
    clear();
    put(0, 16'h1100); put(1, 16'h3101); put(2, 16'h2102); put(3, 16'h4103);
    put(4, 16'h2104); put(5, 16'h6008); put(6, 16'h1101); put(7, 16'hF000);
    put(8, 16'h1105); put(9, 16'h6000); put(10, 16'h7ABC); put(11, 16'h4101);
    put(12, 16'h3106); put(13, 16'h2107); put(14, 16'h5010); put(15, 16'hF000);
    put(16, 16'h1108); put(17, 16'h5013); put(18, 16'h0000); put(19, 16'h6015);
    put(20, 16'h2109); put(21, 16'hF000);
    put(12'h100, 16'd5); put(12'h101, 16'd7); put(12'h103, 16'd12);
    put(12'h105, 16'h8000); put(12'h106, 16'hFFFF); put(12'h108, 16'h0000);
    put(12'h109, 16'h5A5A);
    run(90);
    check_mem(12'h102, "R6");
    check_mem(12'h104, "R6 R7");
    check_mem(12'h107, "R5 R6");
    check_mem(12'h109, "R8");
    total++;
    if (halted !== 1'b1) fail("R9", "halted at end", {31'd0, halted}, 32'd1);

    put(0, 16'h1010); put(1, 16'h2011); put(2, 16'hE000); put(3, 16'h3010);
    put(4, 16'h2FFF); put(5, 16'hF000);
    put(12'h010, 16'hABCD); put(12'h011, 16'h0000); put(12'hFFF, 16'h1111);
    run(30);
    check_mem(12'h011, "R1 R6");
    check_mem(12'hFFF, "R5 R6");
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule